// File: doc/BRIEF.md
# DDR Pad Output Serializer with Output Enable

This block sits between core logic and one group of SIZE output pads. It takes a core-side data bus and an output-enable bus and produces, for each pad, the value to drive and whether the buffer drives at all. A build-time mode selects how the data reaches the pad. It can pass straight through. It can go through one register clocked on the full-rate clock. It can be double-data-rate, with two words per full-rate cycle. Or it can be double-data-rate fed from a half-rate clock domain, which takes four words per half-rate cycle.

The enable path follows the data path's mode but never runs at double rate. In bypass it is a wire. In the single-register and full-rate DDR modes it is one register. In the half-rate mode it is one half-rate capture stage followed by a full-rate register, which gives one enable word per full-rate cycle. Both paths share the clocks and the asynchronous clear. A build option turns the pad into an open-drain driver. A second option makes the data registers preset to all ones instead of clearing.

The half-rate clock must run at half the full-rate frequency, with its rising edges on rising edges of the full-rate clock.

Top module: `ddr_oser`

## Requirements
- R1: In bypass mode, pad_o equals data_i at all times, and outside reset pad_oe_o equals oe_i.
- R2: In single-register mode, data_i and oe_i are captured on each rising full-rate edge. They appear on pad_o and pad_oe_o after that edge and are held for the whole cycle.
- R3: In full-rate DDR mode, data_i is 2×SIZE wide and is captured on the rising full-rate edge. During the following high phase of the full-rate clock pad_o shows data_i[2×SIZE-1:SIZE]. During the low phase it shows data_i[SIZE-1:0].
- R4: In half-rate DDR mode, data_i is 4×SIZE wide and holds words w0..w3, with w0 = bits [SIZE-1:0]. The words are captured on a rising half-rate edge. They leave the pad in the order w0, w1, w2, w3, over the high and low phases of the next two full-rate cycles. A continuous stream has no word skipped or repeated.
- R5: In half-rate DDR mode, oe_i is 2×SIZE wide. oe_i[SIZE-1:0] drives pad_oe_o for the first of those two full-rate cycles and oe_i[2×SIZE-1:SIZE] drives it for the second.
- R6: The enable is active high: 1 drives the pad and 0 releases it. In single-register and full-rate DDR modes the enable is registered on the same edge as the data and is held for the whole cycle.
- R7: With open drain on, pad_o is always 0. pad_oe_o is 1 only where the enable is 1 and the current data bit is 0, so a data 1 releases the pad.
- R8: While rst_ni is low, pad_oe_o is 0 in every mode. The data registers hold 0, or all ones when the preset option is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fr_i | input | 1 | Full-rate clock |
| clk_hr_i | input | 1 | Half-rate clock, edge-aligned with clk_fr_i; used only in half-rate mode |
| rst_ni | input | 1 | Asynchronous clear, active low |
| data_i | input | SIZE×{1,1,2,4} | Core data: bypass, single-register, full-rate DDR, half-rate DDR |
| oe_i | input | SIZE×{1,1,1,2} | Core output enable, active high |
| pad_o | output | SIZE | Value presented to the pad buffers |
| pad_oe_o | output | SIZE | Buffer drive enable per pad |

## Verification
The assertions check four things on every clock of the affected mode. First, that the enable is released throughout reset. Second, that the single-register output and the full-rate low-phase word match the inputs of the previous edge. Third, that at every half-rate edge the pad carries w1 and the first enable word of the previous capture. Fourth, that in open-drain mode the drive enable equals the enable masked by the inverted low-phase data bit. Only the bench scenarios can show the full word order within each phase. They also cover the high-phase words that a preponed sample cannot see, the handover of words across a continuous half-rate stream, the preset value, and the asynchronous effect of a reset asserted in the middle of a cycle.

// File: rtl/ddr_oser_pkg.sv
`timescale 1ns/1ps
package ddr_oser_pkg;

  typedef enum logic [1:0] {
    PM_BYPASS = 2'd0,
    PM_SDR    = 2'd1,
    PM_DDR    = 2'd2,
    PM_DDR_HR = 2'd3
  } path_mode_e;

  function automatic int din_mult(path_mode_e m);
    case (m)
      PM_DDR:    return 2;
      PM_DDR_HR: return 4;
      default:   return 1;
    endcase
  endfunction

  function automatic int oe_mult(path_mode_e m);
    return (m == PM_DDR_HR) ? 2 : 1;
  endfunction

endpackage

// File: rtl/oser_sdr_reg.sv
`timescale 1ns/1ps
module oser_sdr_reg #(
  parameter int   W       = 1,
  parameter logic RST_BIT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= {W{RST_BIT}};
    else         q_o <= d_i;
  end
endmodule

// File: rtl/oser_hr_xfer.sv
`timescale 1ns/1ps
// Holds a word pair per half-rate cycle; presents word 0 in the first
// full-rate cycle after the half-rate edge and word 1 in the second.
module oser_hr_xfer #(
  parameter int   W       = 1,
  parameter logic RST_BIT = 1'b0
) (
  input  logic           clk_hr_i,
  input  logic           clk_fr_i,
  input  logic           rst_ni,
  input  logic [2*W-1:0] pair_i,
  output logic [W-1:0]   word_o
);
  logic [2*W-1:0] hold_q;
  logic           hr_tog_q;
  logic           fr_seen_q;

  always_ff @(posedge clk_hr_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= {(2*W){RST_BIT}};
      hr_tog_q <= 1'b0;
    end else begin
      hold_q   <= pair_i;
      hr_tog_q <= ~hr_tog_q;
    end
  end

  always_ff @(posedge clk_fr_i or negedge rst_ni) begin
    if (!rst_ni) fr_seen_q <= 1'b0;
    else         fr_seen_q <= hr_tog_q;
  end

  // toggle not yet seen by the full-rate side: first slot of the pair
  assign word_o = (hr_tog_q != fr_seen_q) ? hold_q[W-1:0] : hold_q[2*W-1:W];
endmodule

// File: rtl/oser_ddr_out.sv
`timescale 1ns/1ps
module oser_ddr_out #(
  parameter int   W       = 1,
  parameter logic RST_BIT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] rise_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= {W{RST_BIT}};
      fall_q <= {W{RST_BIT}};
    end else begin
      rise_q <= rise_i;
      fall_q <= fall_i;
    end
  end

  assign q_o = clk_i ? rise_q : fall_q;
endmodule

// File: rtl/ddr_oser.sv
`timescale 1ns/1ps
module ddr_oser
  import ddr_oser_pkg::*;
#(
  parameter int         SIZE       = 4,
  parameter path_mode_e MODE       = PM_DDR_HR,
  parameter bit         OPEN_DRAIN = 1'b0,
  parameter bit         PRESET     = 1'b0
) (
  input  logic                             clk_fr_i,
  input  logic                             clk_hr_i,
  input  logic                             rst_ni,
  input  logic [SIZE*din_mult(MODE)-1:0]   data_i,
  input  logic [SIZE*oe_mult(MODE)-1:0]    oe_i,
  output logic [SIZE-1:0]                  pad_o,
  output logic [SIZE-1:0]                  pad_oe_o
);
  localparam int   DIN_W = SIZE * din_mult(MODE);
  localparam int   OE_W  = SIZE * oe_mult(MODE);
  localparam logic DRST  = PRESET;

  logic [SIZE-1:0] dat_w;
  logic [SIZE-1:0] en_w;
  logic [SIZE-1:0] en_live;

  generate
    if (MODE == PM_BYPASS) begin : g_byp
      logic unused_clk;
      assign unused_clk = clk_fr_i ^ clk_hr_i;
      assign dat_w = data_i;
      assign en_w  = oe_i;
    end else if (MODE == PM_SDR) begin : g_sdr
      logic unused_clk;
      assign unused_clk = clk_hr_i;
      oser_sdr_reg #(.W(SIZE), .RST_BIT(DRST)) u_dat (
        .clk_i(clk_fr_i), .rst_ni(rst_ni), .d_i(data_i), .q_o(dat_w));
      oser_sdr_reg #(.W(SIZE), .RST_BIT(1'b0)) u_en (
        .clk_i(clk_fr_i), .rst_ni(rst_ni), .d_i(oe_i), .q_o(en_w));
    end else if (MODE == PM_DDR) begin : g_ddr
      logic unused_clk;
      assign unused_clk = clk_hr_i;
      oser_ddr_out #(.W(SIZE), .RST_BIT(DRST)) u_dat (
        .clk_i(clk_fr_i), .rst_ni(rst_ni),
        .rise_i(data_i[DIN_W-1:SIZE]), .fall_i(data_i[SIZE-1:0]), .q_o(dat_w));
      oser_sdr_reg #(.W(SIZE), .RST_BIT(1'b0)) u_en (
        .clk_i(clk_fr_i), .rst_ni(rst_ni), .d_i(oe_i), .q_o(en_w));
    end else begin : g_hr
      logic [2*SIZE-1:0] pair_w;
      logic [SIZE-1:0]   en_word_w;
      oser_hr_xfer #(.W(2*SIZE), .RST_BIT(DRST)) u_dx (
        .clk_hr_i(clk_hr_i), .clk_fr_i(clk_fr_i), .rst_ni(rst_ni),
        .pair_i(data_i), .word_o(pair_w));
      // earlier word of the pair goes out in the high phase
      oser_ddr_out #(.W(SIZE), .RST_BIT(DRST)) u_dat (
        .clk_i(clk_fr_i), .rst_ni(rst_ni),
        .rise_i(pair_w[SIZE-1:0]), .fall_i(pair_w[2*SIZE-1:SIZE]), .q_o(dat_w));
      oser_hr_xfer #(.W(SIZE), .RST_BIT(1'b0)) u_ex (
        .clk_hr_i(clk_hr_i), .clk_fr_i(clk_fr_i), .rst_ni(rst_ni),
        .pair_i(oe_i[OE_W-1:0]), .word_o(en_word_w));
      oser_sdr_reg #(.W(SIZE), .RST_BIT(1'b0)) u_en (
        .clk_i(clk_fr_i), .rst_ni(rst_ni), .d_i(en_word_w), .q_o(en_w));
    end
  endgenerate

  assign en_live = rst_ni ? en_w : '0;

  generate
    if (OPEN_DRAIN) begin : g_od
      assign pad_o    = '0;
      assign pad_oe_o = en_live & ~dat_w;
    end else begin : g_pp
      assign pad_o    = dat_w;
      assign pad_oe_o = en_live;
    end
  endgenerate
endmodule

// File: rtl/ddr_oser_chk.sv
`timescale 1ns/1ps
module ddr_oser_chk
  import ddr_oser_pkg::*;
#(
  parameter int         SIZE       = 4,
  parameter path_mode_e MODE       = PM_DDR_HR,
  parameter bit         OPEN_DRAIN = 1'b0
) (
  input logic                           clk_fr_i,
  input logic                           clk_hr_i,
  input logic                           rst_ni,
  input logic [SIZE*din_mult(MODE)-1:0] data_i,
  input logic [SIZE*oe_mult(MODE)-1:0]  oe_i,
  input logic [SIZE-1:0]                pad_o,
  input logic [SIZE-1:0]                pad_oe_o
);
  logic unused_bits;
  assign unused_bits = ^{data_i, oe_i, pad_o, clk_hr_i};

  always @(negedge clk_fr_i) begin
    if (!rst_ni) begin
      p_oe_off_in_reset_r8: assert (pad_oe_o == '0);
    end
  end

  generate
    if (MODE == PM_SDR && !OPEN_DRAIN) begin : g_sdr
      p_sdr_hold_r2: assert property (@(posedge clk_fr_i) disable iff (!rst_ni)
        $past(rst_ni) |-> pad_o == $past(data_i));
    end
    if ((MODE == PM_SDR || MODE == PM_DDR) && !OPEN_DRAIN) begin : g_en
      p_en_registered_r6: assert property (@(posedge clk_fr_i) disable iff (!rst_ni)
        $past(rst_ni) |-> pad_oe_o == $past(oe_i[SIZE-1:0]));
    end
    if (MODE == PM_DDR && !OPEN_DRAIN) begin : g_ddr
      p_ddr_fall_word_r3: assert property (@(posedge clk_fr_i) disable iff (!rst_ni)
        $past(rst_ni) |-> pad_o == $past(data_i[SIZE-1:0]));
    end
    if (MODE == PM_DDR && OPEN_DRAIN) begin : g_od
      p_od_release_r7: assert property (@(posedge clk_fr_i) disable iff (!rst_ni)
        $past(rst_ni) |-> pad_oe_o == ($past(oe_i[SIZE-1:0]) & ~$past(data_i[SIZE-1:0])));
    end
    if (MODE == PM_DDR_HR && !OPEN_DRAIN) begin : g_hr
      p_hr_second_word_r4: assert property (@(posedge clk_hr_i) disable iff (!rst_ni)
        $past(rst_ni) |-> pad_o == $past(data_i[2*SIZE-1:SIZE]));
      p_hr_first_en_r5: assert property (@(posedge clk_hr_i) disable iff (!rst_ni)
        $past(rst_ni) |-> pad_oe_o == $past(oe_i[SIZE-1:0]));
    end
  endgenerate
endmodule

bind ddr_oser ddr_oser_chk #(
  .SIZE(SIZE), .MODE(MODE), .OPEN_DRAIN(OPEN_DRAIN)
) u_chk (
  .clk_fr_i(clk_fr_i), .clk_hr_i(clk_hr_i), .rst_ni(rst_ni),
  .data_i(data_i), .oe_i(oe_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o)
);

// File: tb/tb_ddr_oser.sv
`timescale 1ns/1ps
module tb_ddr_oser;
  import ddr_oser_pkg::*;

  logic clk_fr = 1'b0;
  logic clk_hr = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_fr = ~clk_fr;            // 250 MHz
  initial begin #2; forever begin clk_hr = ~clk_hr; #4; end end

  logic [15:0] d_hr;  logic [7:0] oe_hr;
  logic [7:0]  d_fr;  logic [3:0] oe_fr;
  logic [3:0]  d_sdr; logic [3:0] oe_sdr;
  logic [3:0]  d_byp; logic [3:0] oe_byp;
  logic [7:0]  d_od;  logic [3:0] oe_od;
  logic [3:0]  p_hr, e_hr, p_fr, e_fr, p_sdr, e_sdr, p_byp, e_byp, p_od, e_od;

  ddr_oser #(.SIZE(4), .MODE(PM_DDR_HR)) dut (
    .clk_fr_i(clk_fr), .clk_hr_i(clk_hr), .rst_ni(rst_ni),
    .data_i(d_hr), .oe_i(oe_hr), .pad_o(p_hr), .pad_oe_o(e_hr));
  ddr_oser #(.SIZE(4), .MODE(PM_DDR)) dut_ddr (
    .clk_fr_i(clk_fr), .clk_hr_i(clk_hr), .rst_ni(rst_ni),
    .data_i(d_fr), .oe_i(oe_fr), .pad_o(p_fr), .pad_oe_o(e_fr));
  ddr_oser #(.SIZE(4), .MODE(PM_SDR), .PRESET(1'b1)) dut_sdr (
    .clk_fr_i(clk_fr), .clk_hr_i(clk_hr), .rst_ni(rst_ni),
    .data_i(d_sdr), .oe_i(oe_sdr), .pad_o(p_sdr), .pad_oe_o(e_sdr));
  ddr_oser #(.SIZE(4), .MODE(PM_BYPASS)) dut_byp (
    .clk_fr_i(clk_fr), .clk_hr_i(clk_hr), .rst_ni(rst_ni),
    .data_i(d_byp), .oe_i(oe_byp), .pad_o(p_byp), .pad_oe_o(e_byp));
  ddr_oser #(.SIZE(4), .MODE(PM_DDR), .OPEN_DRAIN(1'b1)) dut_od (
    .clk_fr_i(clk_fr), .clk_hr_i(clk_hr), .rst_ni(rst_ni),
    .data_i(d_od), .oe_i(oe_od), .pad_o(p_od), .pad_oe_o(e_od));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model state
  logic [3:0]  m_sdr_q, m_sdr_oe, m_fr_oe, m_od_oe, m_hr_en;
  logic [7:0]  m_fr_q, m_od_q, m_hr_pair;
  logic [15:0] m_hr_cap;
  logic [7:0]  m_hr_oe_cap;

  task automatic model_reset();
    m_sdr_q = 4'hF; m_sdr_oe = '0;
    m_fr_q = '0; m_fr_oe = '0; m_od_q = '0; m_od_oe = '0;
    m_hr_cap = '0; m_hr_oe_cap = '0; m_hr_pair = '0; m_hr_en = '0;
  endtask

  initial model_reset();

  always @(posedge clk_fr) begin
    #1;  // high phase
    if (rst_ni) begin
      m_sdr_q = d_sdr; m_sdr_oe = oe_sdr;
      m_fr_q = d_fr;   m_fr_oe = oe_fr;
      m_od_q = d_od;   m_od_oe = oe_od;
      if (clk_hr) begin
        m_hr_pair = m_hr_cap[15:8]; m_hr_en = m_hr_oe_cap[7:4];
        m_hr_cap = d_hr; m_hr_oe_cap = oe_hr;
      end else begin
        m_hr_pair = m_hr_cap[7:0]; m_hr_en = m_hr_oe_cap[3:0];
      end
    end else model_reset();
    if (!done) begin
      chk(rst_ni ? "R2 sdr data" : "R8 sdr preset", p_sdr, m_sdr_q);
      chk(rst_ni ? "R2 sdr oe" : "R8 sdr oe", e_sdr, m_sdr_oe);
      chk(rst_ni ? "R3 ddr high-phase word" : "R8 ddr clear", p_fr, m_fr_q[7:4]);
      chk(rst_ni ? "R6 ddr oe" : "R8 ddr oe", e_fr, m_fr_oe);
      chk(rst_ni ? "R4 hr high-phase word" : "R8 hr clear", p_hr, m_hr_pair[3:0]);
      chk(rst_ni ? "R5 hr oe" : "R8 hr oe", e_hr, m_hr_en);
      chk("R1 bypass data", p_byp, d_byp);
      chk(rst_ni ? "R1 bypass oe" : "R8 bypass oe", e_byp, rst_ni ? oe_byp : 4'h0);
      chk("R7 od pad low", p_od, 4'h0);
      chk("R7 od drive high phase", e_od, m_od_oe & ~m_od_q[7:4]);
    end
    #2;  // low phase, after the negedge stimulus update
    if (!rst_ni) model_reset();
    if (!done) begin
      chk(rst_ni ? "R2 sdr held" : "R8 sdr preset", p_sdr, m_sdr_q);
      chk(rst_ni ? "R6 sdr oe held" : "R8 sdr oe", e_sdr, m_sdr_oe);
      chk(rst_ni ? "R3 ddr low-phase word" : "R8 ddr clear", p_fr, m_fr_q[3:0]);
      chk(rst_ni ? "R6 ddr oe held" : "R8 ddr oe", e_fr, m_fr_oe);
      chk(rst_ni ? "R4 hr low-phase word" : "R8 hr clear", p_hr, m_hr_pair[7:4]);
      chk(rst_ni ? "R5 hr oe held" : "R8 hr oe", e_hr, m_hr_en);
      chk("R1 bypass data", p_byp, d_byp);
      chk(rst_ni ? "R1 bypass oe" : "R8 bypass oe", e_byp, rst_ni ? oe_byp : 4'h0);
      chk("R7 od pad low", p_od, 4'h0);
      chk("R7 od drive low phase", e_od, m_od_oe & ~m_od_q[3:0]);
    end
  end

  task automatic drive(int i);
    if (i < 40) begin
      d_hr = 16'(i * 16'h1357); oe_hr = 8'(i * 8'h3B);
      d_fr = 8'(i * 8'h25);     oe_fr = 4'(i);
      d_sdr = 4'(i);            oe_sdr = 4'(~i);
      d_byp = 4'(i * 3);        oe_byp = 4'(i * 5);
      d_od = 8'(i * 8'h19);     oe_od = 4'hF;
    end else if (i < 200) begin
      d_hr = 16'($urandom); oe_hr = 8'($urandom);
      d_fr = 8'($urandom);  oe_fr = 4'($urandom);
      d_sdr = 4'($urandom); oe_sdr = 4'($urandom);
      d_byp = 4'($urandom); oe_byp = 4'($urandom);
      d_od = 8'($urandom);  oe_od = 4'($urandom);
    end else begin
      d_hr = i[0] ? 16'hAAAA : 16'h5555; oe_hr = i[1] ? 8'hFF : 8'h00;
      d_fr = i[0] ? 8'hF0 : 8'h0F;       oe_fr = i[1] ? 4'hF : 4'h0;
      d_sdr = i[0] ? 4'hF : 4'h0;        oe_sdr = i[0] ? 4'h0 : 4'hF;
      d_byp = i[0] ? 4'hA : 4'h5;        oe_byp = i[1] ? 4'hF : 4'h0;
      d_od = i[0] ? 8'hA5 : 8'h5A;       oe_od = i[1] ? 4'hF : 4'h6;
    end
  endtask

  initial begin
    drive(0);
    repeat (3) @(negedge clk_fr);
    rst_ni = 1'b1;
    for (int i = 1; i < 300; i++) begin
      @(negedge clk_fr);
      drive(i);
      if (i == 121) rst_ni = 1'b0;   // mid-run asynchronous clear (R8)
      if (i == 124) rst_ni = 1'b1;
    end
    repeat (4) @(negedge clk_fr);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule